// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the configuration of a small bank of general-purpose pins and drives the pad controls that follow from it. Each pin owns two 32-bit registers. The control word chooses which on-chip function reaches the pin, the pull bias, a compact drive-strength code and whether the pin drives at all. The I/O word holds the level the pin drives and shows the level seen at the pad.

Software reaches the registers through a plain register port. A one-cycle write strobe carries a pin index, a register select and a data word. The read data is a combinational view of whichever pin and register the same index and select point at. The configured values go straight from the register flops to per-pin pad outputs. The pad input passes through a two-flop synchroniser before it becomes visible. Because the output level has its own register, software can load it while the pin is still an input and then turn on the output enable, so the pad never drives a stale level.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every pin has function 0, bias code 0, drive code 0, output enable 0 and output level 0, and both registers of every pin read as zero while the pad inputs are low.
- R2: A write with `reg_sel`=0 loads bits [2:0] of `wdata` as the function index of the addressed pin, and that index appears on `pad_func` at the next clock edge.
- R3: Bits [9:8] of the control word hold the bias code (0 = none, 1 = pull-down, 2 = bus keeper, 3 = pull-up), and the code reaches `pad_pull` at the next clock edge.
- R4: Bits [6:4] of the control word hold the drive code c, which stands for (c+1)*2 mA, so codes 0 to 7 span 2 mA to 16 mA. The code reaches `pad_drv` at the next clock edge.
- R5: Bit 12 of the control word is the output enable (1 = drive, 0 = input) and reaches `pad_oe` at the next clock edge.
- R6: A write with `reg_sel`=1 loads bit 0 of `wdata` as the output level, which reaches `pad_out` at the next clock edge whatever the output enable is, so the level can be set before the enable.
- R7: Bit 1 of the I/O register reads the pad input level after two clock edges of synchronisation, whether or not the pin drives.
- R8: Writes to bit 1 of the I/O register and to any bit not named above are ignored. Those bits read as zero, so a control word reads back masked by 0x00001377 and an I/O word by 0x00000003 apart from the input bit.
- R9: A write changes only the addressed register of the addressed pin. All other registers keep their contents.
- R10: `rdata` follows `pin_sel` and `reg_sel` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| pin_sel | input | 3 | Pin index for reads and writes |
| reg_sel | input | 1 | 0 = control word, 1 = I/O word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| pad_in | input | 8 | Pad input levels, one per pin |
| pad_out | output | 8 | Output level per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_func | output | 24 | 3-bit function index per pin, pin i at [3i+2:3i] |
| pad_pull | output | 16 | 2-bit bias code per pin, pin i at [2i+1:2i] |
| pad_drv | output | 24 | 3-bit drive code per pin, pin i at [3i+2:3i] |

## Verification
Every pad-side control and every stored register bit changes at the first clock edge after the write strobe is sampled. A change on a pad input shows up in the read data only after the second edge. The read data itself moves with the index and select inside the same cycle. The bench model uses these same delays: it updates its register image at each edge, sends pad inputs through two model stages, and compares all pad outputs and the current read data 5 ns after every rising edge. Inputs change only on falling edges. Directed checks sample the synchroniser output after one edge and again after two, and sample the read data 1 ns after a change of index with no edge in between.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int REG_W    = 32;
    localparam int FUNC_W   = 3;
    localparam int PULL_W   = 2;
    localparam int DRV_W    = 3;

    // control word field positions
    localparam int FUNC_LSB = 0;
    localparam int DRV_LSB  = 4;
    localparam int PULL_LSB = 8;
    localparam int OE_BIT   = 12;

    // I/O word field positions
    localparam int OUT_BIT  = 0;
    localparam int IN_BIT   = 1;

    typedef enum logic [PULL_W-1:0] {
        BIAS_NONE = 2'd0,
        BIAS_DOWN = 2'd1,
        BIAS_KEEP = 2'd2,
        BIAS_UP   = 2'd3
    } bias_e;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_IO   = 1'b1
    } regsel_e;

    typedef struct packed {
        logic              oe;
        bias_e             pull;
        logic [DRV_W-1:0]  drv;
        logic [FUNC_W-1:0] func;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  out;
    } pin_state_t;

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[FUNC_LSB +: FUNC_W] = c.func;
        w[DRV_LSB  +: DRV_W]  = c.drv;
        w[PULL_LSB +: PULL_W] = c.pull;
        w[OE_BIT]             = c.oe;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.func = w[FUNC_LSB +: FUNC_W];
        c.drv  = w[DRV_LSB  +: DRV_W];
        c.pull = bias_e'(w[PULL_LSB +: PULL_W]);
        c.oe   = w[OE_BIT];
        return c;
    endfunction

    localparam logic [REG_W-1:0] CTRL_MASK = ctrl_to_word('{oe: 1'b1, pull: BIAS_UP,
                                                            drv: '1, func: '1});
    localparam logic [REG_W-1:0] IO_MASK   = (REG_W'(1) << OUT_BIT) | (REG_W'(1) << IN_BIT);

endpackage

// File: rtl/gpb_pin_regs.sv
module gpb_pin_regs
    import gpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_io,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic             out_q
);

    pin_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_ctrl) begin
            state_d.ctrl = word_to_ctrl(wdata);
        end
        if (wr_io) begin
            state_d.out = wdata[OUT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_q = state_q.ctrl;
    assign out_q  = state_q.out;

    // R9: without a strobe the registers keep their contents
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));
    p_io_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_io |=> $stable(out_q));

    // R2: a control write lands one edge later
    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q.func == $past(wdata[FUNC_LSB +: FUNC_W])) &&
                    (ctrl_q.oe == $past(wdata[OE_BIT])));

    // R6: the output level lands one edge later whatever the enable is
    p_io_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_io |=> out_q == $past(wdata[OUT_BIT]));

endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef logic [STAGES-1:0][W-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] age_d, age_q;

            always_comb begin
                age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    age_q <= '0;
                end else begin
                    age_q <= age_d;
                end
            end

            // R7: the synchronised level is the pad level from two edges back
            p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd2) |-> q == $past(d, 2));
        end
    endgenerate

endmodule

// File: rtl/gpb_read_mux.sv
module gpb_read_mux
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 3
) (
    input  ctrl_t            ctrl   [NUM_PINS],
    input  logic [NUM_PINS-1:0] out_lvl,
    input  logic [NUM_PINS-1:0] in_lvl,
    input  logic [IDX_W-1:0] pin_sel,
    input  logic             reg_sel,
    output logic [REG_W-1:0] rdata
);

    logic sel_valid;

    always_comb begin
        sel_valid = (int'(pin_sel) < NUM_PINS);
        rdata     = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_valid && (int'(pin_sel) == i)) begin
                if (regsel_e'(reg_sel) == SEL_CTRL) begin
                    rdata = ctrl_to_word(ctrl[i]);
                end else begin
                    rdata[OUT_BIT] = out_lvl[i];
                    rdata[IN_BIT]  = in_lvl[i];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpb_pkg::*;
#(
    parameter  int NUM_PINS    = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int IDX_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           pin_sel,
    input  logic                       reg_sel,
    input  logic [REG_W-1:0]           wdata,
    output logic [REG_W-1:0]           rdata,
    input  logic [NUM_PINS-1:0]        pad_in,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [NUM_PINS*FUNC_W-1:0] pad_func,
    output logic [NUM_PINS*PULL_W-1:0] pad_pull,
    output logic [NUM_PINS*DRV_W-1:0]  pad_drv
);

    logic [NUM_PINS-1:0] wr_ctrl_vec;
    logic [NUM_PINS-1:0] wr_io_vec;
    logic [NUM_PINS-1:0] out_lvl;
    logic [NUM_PINS-1:0] in_sync;
    ctrl_t               ctrl_arr [NUM_PINS];

    gpb_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            always_comb begin
                wr_ctrl_vec[i] = wr_en && (int'(pin_sel) == i) &&
                                 (regsel_e'(reg_sel) == SEL_CTRL);
                wr_io_vec[i]   = wr_en && (int'(pin_sel) == i) &&
                                 (regsel_e'(reg_sel) == SEL_IO);
            end

            gpb_pin_regs u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_ctrl (wr_ctrl_vec[i]),
                .wr_io   (wr_io_vec[i]),
                .wdata   (wdata),
                .ctrl_q  (ctrl_arr[i]),
                .out_q   (out_lvl[i])
            );

            assign pad_func[i*FUNC_W +: FUNC_W] = ctrl_arr[i].func;
            assign pad_pull[i*PULL_W +: PULL_W] = ctrl_arr[i].pull;
            assign pad_drv[i*DRV_W +: DRV_W]    = ctrl_arr[i].drv;
            assign pad_oe[i]                    = ctrl_arr[i].oe;
            assign pad_out[i]                   = out_lvl[i];

            // R5: the enable only changes through a control write to this pin
            p_oe_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_ctrl_vec[i] |=> $stable(pad_oe[i]));
        end
    endgenerate

    gpb_read_mux #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_rd (
        .ctrl    (ctrl_arr),
        .out_lvl (out_lvl),
        .in_lvl  (in_sync),
        .pin_sel (pin_sel),
        .reg_sel (reg_sel),
        .rdata   (rdata)
    );

    // R8: unnamed bits read as zero
    p_ctrl_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regsel_e'(reg_sel) == SEL_CTRL) |-> (rdata & ~CTRL_MASK) == '0);
    p_io_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regsel_e'(reg_sel) == SEL_IO) |-> (rdata & ~IO_MASK) == '0);

    // R9: at most one register of one pin is written per cycle
    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ctrl_vec, wr_io_vec}));

endmodule

// File: tb/tb_gpio_pad_bank.sv
module tb_gpio_pad_bank;

    localparam int NP = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      pin_sel = '0;
    logic            reg_sel = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out;
    logic [NP-1:0]   pad_oe;
    logic [NP*3-1:0] pad_func;
    logic [NP*2-1:0] pad_pull;
    logic [NP*3-1:0] pad_drv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural image of the bank
    int m_func [NP];
    int m_pull [NP];
    int m_drv  [NP];
    int m_oe   [NP];
    int m_out  [NP];
    int m_s1   [NP];
    int m_in   [NP];

    gpio_pad_bank dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .pin_sel  (pin_sel),
        .reg_sel  (reg_sel),
        .wdata    (wdata),
        .rdata    (rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_func (pad_func),
        .pad_pull (pad_pull),
        .pad_drv  (pad_drv)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input int p, input int sel);
        if (sel == 0)
            return 32'(m_func[p]) | (32'(m_drv[p]) << 4) | (32'(m_pull[p]) << 8) |
                   (32'(m_oe[p]) << 12);
        return 32'(m_out[p]) | (32'(m_in[p]) << 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_func[i] <= 0; m_pull[i] <= 0; m_drv[i] <= 0;
                m_oe[i] <= 0; m_out[i] <= 0; m_s1[i] <= 0; m_in[i] <= 0;
            end
        end else begin
            for (int i = 0; i < NP; i++) begin
                m_s1[i] <= int'(pad_in[i]);
                m_in[i] <= m_s1[i];
            end
            if (wr_en) begin
                if (reg_sel == 1'b0) begin
                    m_func[pin_sel] <= int'(wdata[2:0]);
                    m_drv[pin_sel]  <= int'(wdata[6:4]);
                    m_pull[pin_sel] <= int'(wdata[9:8]);
                    m_oe[pin_sel]   <= int'(wdata[12]);
                end else begin
                    m_out[pin_sel]  <= int'(wdata[0]);
                end
            end
        end
    end

    // compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            for (int i = 0; i < NP; i++) begin
                chk("R2 pad_func", 32'(pad_func[i*3 +: 3]), 32'(m_func[i]));
                chk("R3 pad_pull", 32'(pad_pull[i*2 +: 2]), 32'(m_pull[i]));
                chk("R4 pad_drv",  32'(pad_drv[i*3 +: 3]),  32'(m_drv[i]));
                chk("R5 pad_oe",   32'(pad_oe[i]),          32'(m_oe[i]));
                chk("R6 pad_out",  32'(pad_out[i]),         32'(m_out[i]));
            end
            chk("R10 rdata", rdata, model_word(int'(pin_sel), int'(reg_sel)));
        end
    end

    task automatic wr(input int p, input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; pin_sel = 3'(p); reg_sel = sel[0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] cw(input int f, input int dr, input int pl, input int oe);
        return 32'(f) | (32'(dr) << 4) | (32'(pl) << 8) | (32'(oe) << 12);
    endfunction

    task automatic rd_chk(input string tag, input int p, input int sel, input logic [31:0] exp);
        pin_sel = 3'(p); reg_sel = sel[0];
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pad_func", 32'(pad_func), 32'd0);
        chk("R1 pad_pull", 32'(pad_pull), 32'd0);
        chk("R1 pad_drv",  32'(pad_drv),  32'd0);
        chk("R1 pad_oe",   32'(pad_oe),   32'd0);
        chk("R1 pad_out",  32'(pad_out),  32'd0);
        for (int p = 0; p < NP; p++) begin
            rd_chk("R1 ctrl read", p, 0, 32'd0);
            rd_chk("R1 io read",   p, 1, 32'd0);
        end

        // R2 R5: full control word on pin 3
        wr(3, 0, cw(5, 6, 2, 1));
        chk("R2 func pin3", 32'(pad_func[9 +: 3]), 32'd5);
        chk("R5 oe pin3",   32'(pad_oe[3]), 32'd1);
        chk("R3 keeper pin3", 32'(pad_pull[6 +: 2]), 32'd2);

        // R6: preload the level while still an input, then enable
        wr(2, 1, 32'h1);
        chk("R6 level before enable", 32'(pad_out[2]), 32'd1);
        chk("R6 still input", 32'(pad_oe[2]), 32'd0);
        wr(2, 0, cw(1, 0, 0, 1));
        chk("R6 level after enable", 32'(pad_out[2]), 32'd1);
        chk("R5 enable set", 32'(pad_oe[2]), 32'd1);

        // R3: every bias code on pin 1
        for (int b = 0; b < 4; b++) begin
            wr(1, 0, cw(0, 0, b, 0));
            chk("R3 bias code", 32'(pad_pull[2 +: 2]), 32'(b));
        end

        // R4: every drive code on pin 4 maps to (c+1)*2 mA
        for (int ma = 2; ma <= 16; ma += 2) begin
            wr(4, 0, cw(0, ma / 2 - 1, 0, 0));
            chk("R4 drive code", 32'(pad_drv[12 +: 3]), 32'(ma / 2 - 1));
        end

        // R8: read-only and unnamed bits
        pad_in[5] = 1'b0;
        wr(5, 1, 32'hFFFF_FFFF);
        rd_chk("R8 io readback", 5, 1, 32'h0000_0001);
        wr(5, 0, 32'hFFFF_FFFF);
        rd_chk("R8 ctrl readback", 5, 0, 32'h0000_1377);

        // R9: neighbours unaffected
        rd_chk("R9 pin4 ctrl", 4, 0, cw(0, 7, 0, 0));
        rd_chk("R9 pin6 ctrl", 6, 0, 32'd0);
        rd_chk("R9 pin6 io",   6, 1, 32'd0);
        rd_chk("R9 pin3 ctrl", 3, 0, cw(5, 6, 2, 1));

        // R7: two-edge input latency, pin 0 driving
        wr(0, 0, cw(0, 0, 0, 1));
        pin_sel = 3'd0; reg_sel = 1'b1;
        @(negedge clk);
        pad_in[0] = 1'b1;
        @(posedge clk); #5;
        chk("R7 one edge", 32'(rdata[1]), 32'd0);
        @(posedge clk); #5;
        chk("R7 two edges", 32'(rdata[1]), 32'd1);
        // R7: same with the pin as an input
        wr(0, 0, cw(0, 0, 0, 0));
        pin_sel = 3'd0; reg_sel = 1'b1;
        @(negedge clk);
        pad_in[0] = 1'b0;
        @(posedge clk); #5;
        chk("R7 input one edge", 32'(rdata[1]), 32'd1);
        @(posedge clk); #5;
        chk("R7 input two edges", 32'(rdata[1]), 32'd0);

        // R10: read follows the index inside one cycle
        @(negedge clk);
        #2;
        rd_chk("R10 same cycle pin3", 3, 0, cw(5, 6, 2, 1));
        rd_chk("R10 same cycle pin2", 2, 1, 32'h1);

        // mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            wr_en   = ($urandom % 3) == 0;
            pin_sel = 3'($urandom);
            reg_sel = 1'($urandom);
            wdata   = $urandom;
            pad_in  = NP'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule